// File: doc/BRIEF.md
# Segment Limit and Protection Checker

This block decides whether a memory access made through a segment register must raise a general-protection fault. The access is made while protection is on and the core is outside 64-bit mode. For each access, the caller presents the linear address, the segment's base, limit, selector and attribute bits, the kind of access and its size in bytes. It also presents the code segment's default-size bit and the per-access address-size override. One clock later the block returns a single fault flag.

The block applies two sets of rules. The first concerns rights: a null selector on a segment that is not exempt faults. Data segments must also permit the requested read or write. The second concerns bounds. The effective address width, 16 or 32 bits, follows from the default-size and override bits. The offset into the segment is the linear address minus the base, cut to that width. The first and last byte of the access are then compared with the limit, and the sense of that comparison is inverted for expand-down segments. When long mode is active or protection is off, no fault is raised. Loading descriptors and delivering the fault belong to other blocks.

Top module: `seg_guard_top`

## Requirements
- R1: When `long_mode` is 1 or `prot_en` is 0, a strobed access never raises `gp_fault`, whatever the other inputs are.
- R2: An all-zero `seg_sel` raises a fault unless `seg_exempt` is 1; an exempt segment with a zero selector is not faulted for that reason.
- R3: When `seg_data` is 1 and `seg_wr` is 0, `acc_mode` 1 (write) or 3 (store check) faults; modes 0 (read) and 2 (execute) do not need write permission; when `seg_data` is 0 neither write nor read permission is checked.
- R4: When `seg_data` is 1 and `seg_rd` is 0, `acc_mode` 0 (read) faults; a write to such a segment is not faulted for readability.
- R5: The effective width is 16 bits when `cs_def32` equals `addr_ovr`, and 32 bits (ADDR_W) otherwise.
- R6: The offset is (`lin_addr` − `seg_base`) modulo 2^width, and the end offset is offset + `acc_size` − 1, computed without loss of the carry.
- R7: For a segment with `seg_expdn` 0, a fault occurs when the offset or the end offset is greater than `seg_limit`; an access whose last byte sits exactly at the limit passes.
- R8: For a segment with `seg_expdn` 1, a fault occurs when the offset or the end offset is less than or equal to `seg_limit`.
- R9: An end offset above the top of the effective address space (0xFFFF or 2^ADDR_W − 1) faults for both segment kinds, so wrap-around never passes.
- R10: `out_valid` is 1 exactly in the cycle after `in_valid` was sampled 1. `gp_fault` takes that access's result at the same edge and holds it while no access is strobed. Both outputs are 0 after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Access strobe |
| prot_en | input | 1 | Protection enabled |
| long_mode | input | 1 | 64-bit mode active (check bypassed) |
| lin_addr | input | ADDR_W | Linear address of first byte |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| seg_sel | input | SEL_W | Segment selector |
| seg_exempt | input | 1 | Segment exempt from the null-selector rule |
| seg_data | input | 1 | Segment is a data segment (rights apply) |
| seg_rd | input | 1 | Segment readable |
| seg_wr | input | 1 | Segment writable |
| seg_expdn | input | 1 | Segment expands downward |
| acc_mode | input | 2 | 0 read, 1 write, 2 execute, 3 store check |
| acc_size | input | SIZE_W | Access size in bytes (1 or more) |
| cs_def32 | input | 1 | Code segment default-size bit |
| addr_ovr | input | 1 | Address-size override |
| out_valid | output | 1 | Result valid |
| gp_fault | output | 1 | General-protection fault |

## Verification
The bound assertions check the one-cycle result timing, the hold of the fault between strobes, the bypass and the rights rules on every cycle. These rules depend only on a few input bits, so the checker can state them directly. The width selection, the subtraction wrap, the exact limit boundaries in both directions and the overflow past the top of the 16- and 32-bit spaces involve arithmetic, so only the bench's directed scenarios show them. The bench uses hand-computed offsets placed exactly on, one below and one past each boundary.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_STCHK = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_guard_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             seg_exempt,
  input  logic             seg_data,
  input  logic             seg_rd,
  input  logic             seg_wr,
  input  logic [1:0]       acc_mode,
  output logic             rights_fault
);
  logic null_fault;
  logic wr_need;
  logic rd_need;

  always_comb begin
    null_fault   = (seg_sel == '0) && !seg_exempt;
    wr_need      = (acc_mode == ACC_WRITE) || (acc_mode == ACC_STCHK);
    rd_need      = (acc_mode == ACC_READ);
    rights_fault = null_fault ||
                   (seg_data && wr_need && !seg_wr) ||
                   (seg_data && rd_need && !seg_rd);
  end
endmodule

// File: rtl/seg_offset_gen.sv
module seg_offset_gen #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SIZE_W   = 4
) (
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              cs_def32,
  input  logic              addr_ovr,
  output logic [ADDR_W-1:0] offset,
  output logic [ADDR_W:0]   end_off,
  output logic [ADDR_W-1:0] top
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] WIDE_MASK   = '1;
  localparam logic [ADDR_W:0]   ONE_X       = 1;

  logic [ADDR_W-1:0] diff;
  logic              narrow;

  always_comb begin
    diff    = lin_addr - seg_base;
    narrow  = (cs_def32 == addr_ovr);
    top     = narrow ? NARROW_MASK : WIDE_MASK;
    offset  = diff & top;
    end_off = {1'b0, offset} + (ADDR_W+1)'(acc_size) - ONE_X;
  end
endmodule

// File: rtl/seg_bound_cmp.sv
module seg_bound_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W:0]   end_off,
  input  logic [ADDR_W-1:0] top,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              seg_expdn,
  output logic              bound_fault
);
  logic [ADDR_W:0] lim_x;
  logic            past_top;
  logic            up_fault;
  logic            dn_fault;

  always_comb begin
    lim_x       = {1'b0, seg_limit};
    past_top    = end_off > {1'b0, top};
    up_fault    = (offset > seg_limit) || (end_off > lim_x);
    dn_fault    = (offset <= seg_limit) || (end_off <= lim_x);
    bound_fault = past_top || (seg_expdn ? dn_fault : up_fault);
  end
endmodule

// File: rtl/seg_guard_top.sv
module seg_guard_top #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SEL_W    = 16,
  parameter int SIZE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              prot_en,
  input  logic              long_mode,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic              seg_exempt,
  input  logic              seg_data,
  input  logic              seg_rd,
  input  logic              seg_wr,
  input  logic              seg_expdn,
  input  logic [1:0]        acc_mode,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              cs_def32,
  input  logic              addr_ovr,
  output logic              out_valid,
  output logic              gp_fault
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W:0]   end_off;
  logic [ADDR_W-1:0] top;
  logic              rights_fault;
  logic              bound_fault;
  logic              check_on;
  logic              fault_next;

  seg_rights_chk #(.SEL_W(SEL_W)) u_rights (
    .seg_sel      (seg_sel),
    .seg_exempt   (seg_exempt),
    .seg_data     (seg_data),
    .seg_rd       (seg_rd),
    .seg_wr       (seg_wr),
    .acc_mode     (acc_mode),
    .rights_fault (rights_fault)
  );

  seg_offset_gen #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .SIZE_W(SIZE_W)) u_offs (
    .lin_addr (lin_addr),
    .seg_base (seg_base),
    .acc_size (acc_size),
    .cs_def32 (cs_def32),
    .addr_ovr (addr_ovr),
    .offset   (offset),
    .end_off  (end_off),
    .top      (top)
  );

  seg_bound_cmp #(.ADDR_W(ADDR_W)) u_bound (
    .offset      (offset),
    .end_off     (end_off),
    .top         (top),
    .seg_limit   (seg_limit),
    .seg_expdn   (seg_expdn),
    .bound_fault (bound_fault)
  );

  always_comb begin
    check_on   = prot_en && !long_mode;
    fault_next = check_on && (rights_fault || bound_fault);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      gp_fault  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) gp_fault <= fault_next;
    end
  end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             prot_en,
  input logic             long_mode,
  input logic [SEL_W-1:0] seg_sel,
  input logic             seg_exempt,
  input logic             seg_data,
  input logic             seg_rd,
  input logic             seg_wr,
  input logic [1:0]       acc_mode,
  input logic             out_valid,
  input logic             gp_fault
);
  logic on_q;
  assign on_q = in_valid && prot_en && !long_mode;

  // R10
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gp_fault));
  // R1
  bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (long_mode || !prot_en)) |=> !gp_fault);
  // R2
  null_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (on_q && (seg_sel == '0) && !seg_exempt) |=> gp_fault);
  // R3
  write_perm_chk: assert property (@(posedge clk) disable iff (rst)
    (on_q && seg_data && !seg_wr && acc_mode[0]) |=> gp_fault);
  // R4
  read_perm_chk: assert property (@(posedge clk) disable iff (rst)
    (on_q && seg_data && !seg_rd && (acc_mode == 2'd0)) |=> gp_fault);
endmodule

bind seg_guard_top seg_guard_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .prot_en    (prot_en),
  .long_mode  (long_mode),
  .seg_sel    (seg_sel),
  .seg_exempt (seg_exempt),
  .seg_data   (seg_data),
  .seg_rd     (seg_rd),
  .seg_wr     (seg_wr),
  .acc_mode   (acc_mode),
  .out_valid  (out_valid),
  .gp_fault   (gp_fault)
);

// File: tb/seg_guard_top_tb.sv
`timescale 1ns/1ps
module seg_guard_top_tb;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int SIZE_W = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic              prot_en, long_mode;
  logic [ADDR_W-1:0] lin_addr, seg_base, seg_limit;
  logic [SEL_W-1:0]  seg_sel;
  logic              seg_exempt, seg_data, seg_rd, seg_wr, seg_expdn;
  logic [1:0]        acc_mode;
  logic [SIZE_W-1:0] acc_size;
  logic              cs_def32, addr_ovr;
  logic              out_valid, gp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_guard_top #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .prot_en(prot_en),
    .long_mode(long_mode), .lin_addr(lin_addr), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_sel(seg_sel), .seg_exempt(seg_exempt),
    .seg_data(seg_data), .seg_rd(seg_rd), .seg_wr(seg_wr),
    .seg_expdn(seg_expdn), .acc_mode(acc_mode), .acc_size(acc_size),
    .cs_def32(cs_def32), .addr_ovr(addr_ovr), .out_valid(out_valid),
    .gp_fault(gp_fault)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // defaults: protected, 32-bit width, data seg rw, normal, base 0x1000 limit 0xFFF
  task automatic set_default();
    prot_en = 1; long_mode = 0; seg_sel = 16'h0010; seg_exempt = 0;
    seg_data = 1; seg_rd = 1; seg_wr = 1; seg_expdn = 0;
    acc_mode = 2'd0; acc_size = 4'd1; cs_def32 = 1; addr_ovr = 0;
    seg_base = 32'h1000; seg_limit = 32'h0FFF; lin_addr = 32'h1000;
  endtask

  // inputs already set at a negedge; strobe one cycle, check at the next negedge
  task automatic run(input string req, input logic exp_fault);
    in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check(req, out_valid, 1'b1);
    check(req, gp_fault, exp_fault);
  endtask

  task automatic t_reset();
    check("R10", out_valid, 1'b0);
    check("R10", gp_fault, 1'b0);
  endtask

  task automatic t_bypass();
    set_default(); seg_sel = '0; long_mode = 1; run("R1", 1'b0);
    set_default(); prot_en = 0; lin_addr = 32'h5000; run("R1", 1'b0);
  endtask

  task automatic t_null_sel();
    set_default(); seg_sel = '0; run("R2", 1'b1);
    set_default(); seg_sel = '0; seg_exempt = 1; run("R2", 1'b0);
  endtask

  task automatic t_write_rights();
    set_default(); seg_wr = 0; acc_mode = 2'd1; run("R3", 1'b1);
    set_default(); seg_wr = 0; acc_mode = 2'd3; run("R3", 1'b1);
    set_default(); seg_wr = 0; acc_mode = 2'd2; run("R3", 1'b0);
    set_default(); seg_wr = 0; acc_mode = 2'd1; seg_data = 0; run("R3", 1'b0);
  endtask

  task automatic t_read_rights();
    set_default(); seg_rd = 0; acc_mode = 2'd0; run("R4", 1'b1);
    set_default(); seg_rd = 0; acc_mode = 2'd1; run("R4", 1'b0);
  endtask

  task automatic t_width();
    // 16-bit: def=0 ovr=0, offset 0x2345 within limit 0x3000
    set_default(); seg_base = 0; seg_limit = 32'h3000; lin_addr = 32'h12345;
    cs_def32 = 0; addr_ovr = 0; run("R5", 1'b0);
    // 16-bit: def=1 ovr=1
    cs_def32 = 1; addr_ovr = 1; run("R5", 1'b0);
    // 32-bit: offset 0x12345 exceeds limit
    cs_def32 = 1; addr_ovr = 0; run("R5", 1'b1);
    cs_def32 = 0; addr_ovr = 1; run("R5", 1'b1);
  endtask

  task automatic t_offset_wrap();
    // lin below base: 32-bit offset 0xFFFFF800 > limit
    set_default(); seg_limit = 32'hFFFF; lin_addr = 32'h0800; acc_size = 4;
    run("R6", 1'b1);
    // 16-bit: offset 0xF800, end 0xF803 <= 0xFFFF
    cs_def32 = 0; run("R6", 1'b0);
  endtask

  task automatic t_normal_limit();
    set_default(); lin_addr = 32'h1FFF; acc_size = 1; run("R7", 1'b0);
    set_default(); lin_addr = 32'h1FFF; acc_size = 2; run("R7", 1'b1);
    set_default(); lin_addr = 32'h2000; acc_size = 1; run("R7", 1'b1);
    set_default(); lin_addr = 32'h1FFC; acc_size = 4; run("R7", 1'b0);
  endtask

  task automatic t_expand_down();
    set_default(); seg_base = 0; seg_expdn = 1; seg_limit = 32'h0FFF;
    lin_addr = 32'h1000; acc_size = 4; run("R8", 1'b0);
    lin_addr = 32'h0FFF; acc_size = 1; run("R8", 1'b1);
    lin_addr = 32'h0FFD; acc_size = 4; run("R8", 1'b1);
    cs_def32 = 0; lin_addr = 32'hFFFC; acc_size = 4; run("R8", 1'b0);
  endtask

  task automatic t_top_wrap();
    set_default(); seg_base = 0; seg_limit = 32'hFFFFF; cs_def32 = 0;
    lin_addr = 32'hFFFE; acc_size = 4; run("R9", 1'b1);
    set_default(); seg_base = 0; seg_limit = 32'hFFFFFFFF;
    lin_addr = 32'hFFFFFFFE; acc_size = 4; run("R9", 1'b1);
    lin_addr = 32'hFFFFFFFC; run("R9", 1'b0);
    set_default(); seg_base = 0; seg_expdn = 1; seg_limit = 32'h0FFF; cs_def32 = 0;
    lin_addr = 32'hFFFE; acc_size = 4; run("R9", 1'b1);
  endtask

  task automatic t_hold();
    set_default(); seg_sel = '0; run("R10", 1'b1);
    set_default();
    @(posedge clk); @(negedge clk);
    check("R10", out_valid, 1'b0);
    check("R10", gp_fault, 1'b1);
    run("R10", 1'b0);
    seg_sel = '0;
    @(posedge clk); @(negedge clk);
    check("R10", gp_fault, 1'b0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    rst = 1; in_valid = 0;
    set_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_null_sel();
    t_write_rights();
    t_read_rights();
    t_width();
    t_offset_wrap();
    t_normal_limit();
    t_expand_down();
    t_top_wrap();
    t_hold();
    done = 1;
    finish_run();
  end
endmodule